// File: doc/BRIEF.md
# ADC Result Queue with Pop-on-Read

This block sits between an analog-to-digital conversion sequencer and a memory-mapped register file. It holds up to 16 finished conversions. Each one pairs a 10-bit sample with the 4-bit index of the sequencer slot that asked for it. The sequencer pushes results through a valid/ready handshake. When all slots are occupied, ready drops and the sequencer must hold its data, so no sample is ever overwritten or lost.

On the register side, the oldest stored result is always visible as a read-only 32-bit word. The register decoder raises a one-cycle read strobe when software reads that word. The strobe returns the word in the same cycle and retires the entry at the next clock edge. A strobe on an empty queue returns zero and changes nothing. The read pointer, the write pointer, the occupancy and the full and empty flags are brought out so that a neighbouring status register can show them.

Top module: `adc_result_queue`

## Requirements
- R1: A synchronous active-high reset sets both pointers and the count to zero, raises `empty`, lowers `full` and makes `rd_data` read zero.
- R2: When the queue holds at least one entry, `rd_data[15:6]` is the oldest entry's sample and `rd_data[3:0]` is its slot tag. Bits 31:16 and 5:4 are always zero.
- R3: Entries are presented in the exact order in which they were accepted. The oldest entry is the one stored at index `rd_ptr`.
- R4: A `rd_strobe` cycle on a non-empty queue retires the oldest entry. `rd_ptr` advances by one modulo 16, and `count` drops by one unless a push is accepted in the same cycle.
- R5: A `rd_strobe` cycle on an empty queue shows `rd_data` as zero and leaves `rd_ptr` unchanged.
- R6: With 16 entries stored and no read strobe, `in_ready` is low. A valid push is then not accepted, `wr_ptr` and `count` stay put, and every stored entry is kept unchanged.
- R7: On a full queue, a cycle with both `rd_strobe` and `in_valid` performs both the retire and the push. `count` stays 16 and both pointers advance.
- R8: A push is accepted when `in_valid` and `in_ready` are both high. It stores the sample and tag at index `wr_ptr`, advances `wr_ptr` by one modulo 16 and raises `count` by one unless a retire happens in the same cycle.
- R9: On a queue that is neither empty nor full, an accepted push together with a retire leaves `count` unchanged.
- R10: `full` is high exactly when `count` is 16, `empty` is high exactly when `count` is 0, and `count` never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sequencer offers a result |
| in_ready | output | 1 | Queue accepts the offered result this cycle |
| in_value | input | 10 | Conversion sample |
| in_tag | input | 4 | Index of the sequencer slot that produced the sample |
| rd_strobe | input | 1 | Bus read of the results word (retires the oldest entry) |
| rd_data | output | 32 | Results word: oldest entry, or zero when empty |
| rd_ptr | output | 4 | Storage index of the oldest entry |
| wr_ptr | output | 4 | Storage index the next push will use |
| count | output | 5 | Number of stored entries, 0 to 16 |
| full | output | 1 | Queue holds 16 entries |
| empty | output | 1 | Queue holds no entries |

## Verification
The first pattern fills the queue with samples and tags drawn from an arithmetic sequence, keeps offering while full, and then drains it. This separates a correct stall from an overwrite and shows whether order is kept across the full boundary. Strobes on an empty queue, and all-ones or all-zero fields, show whether the padding bits stay zero and whether an empty read moves anything. A long run of simultaneous push and retire on a full queue isolates the both-at-once path. A long pseudo-random interleaving of valid and strobe, with fill-biased and drain-biased phases, carries the pointers through many wraps. A reset taken with the queue partly full confirms that stale data disappears from the word.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

    localparam int unsigned VAL_W   = 10;
    localparam int unsigned TAG_W   = 4;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned VAL_LSB = 6;
    localparam int unsigned TAG_LSB = 0;

    // One stored result: sample plus producing slot
    typedef struct packed {
        logic [VAL_W-1:0] value;
        logic [TAG_W-1:0] tag;
    } adcq_entry_t;

    // What the queue does in a given cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } adcq_op_e;

    // Lay an entry out in the bus word; unused bits are zero
    function automatic logic [WORD_W-1:0] adcq_pack(input adcq_entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[VAL_LSB +: VAL_W] = e.value;
        w[TAG_LSB +: TAG_W] = e.tag;
        return w;
    endfunction

endpackage

// File: rtl/adcq_ptr_ctl.sv
module adcq_ptr_ctl
    import adcq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             in_ready,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    adcq_op_e op;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CNT_MAX);
    assign empty    = (count == '0);
    assign pop_ok   = pop_req && !empty;
    // A retire in the same cycle frees the slot the push will take
    assign in_ready = !full || pop_ok;
    assign push_ok  = push_req && in_ready;

    always_comb begin
        unique case ({pop_ok, push_ok})
            2'b01:   op = OP_PUSH;
            2'b10:   op = OP_POP;
            2'b11:   op = OP_BOTH;
            default: op = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    wr_ptr <= step_ptr(wr_ptr);
                    count  <= count + 1'b1;
                end
                OP_POP: begin
                    rd_ptr <= step_ptr(rd_ptr);
                    count  <= count - 1'b1;
                end
                OP_BOTH: begin
                    wr_ptr <= step_ptr(wr_ptr);
                    rd_ptr <= step_ptr(rd_ptr);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adcq_store.sv
module adcq_store
    import adcq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  adcq_entry_t      wr_entry,
    input  logic [PTR_W-1:0] rd_idx,
    output adcq_entry_t      rd_entry
);

    adcq_entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        adcq_entry_t slot_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot_q <= wr_entry;
            end
        end
        assign slots[g] = slot_q;
    end

    assign rd_entry = slots[rd_idx];

endmodule

// File: rtl/adcq_word_fmt.sv
module adcq_word_fmt
    import adcq_pkg::*;
(
    input  adcq_entry_t        head,
    input  logic               empty,
    output logic [WORD_W-1:0]  word
);

    // Stale storage is never shown: an empty queue reads as zero
    assign word = empty ? '0 : adcq_pack(head);

endmodule

// File: rtl/adc_result_queue.sv
module adc_result_queue
    import adcq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VAL_W-1:0]  in_value,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    logic        push_ok;
    logic        pop_ok;
    adcq_entry_t new_entry;
    adcq_entry_t head_entry;

    assign new_entry = '{value: in_value, tag: in_tag};

    adcq_ptr_ctl #(.DEPTH(DEPTH)) ctl_i (
        .clk      (clk),
        .rst      (rst),
        .push_req (in_valid),
        .pop_req  (rd_strobe),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .in_ready (in_ready),
        .rd_ptr   (rd_ptr),
        .wr_ptr   (wr_ptr),
        .count    (count),
        .full     (full),
        .empty    (empty)
    );

    adcq_store #(.DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .wr_en    (push_ok),
        .wr_idx   (wr_ptr),
        .wr_entry (new_entry),
        .rd_idx   (rd_ptr),
        .rd_entry (head_entry)
    );

    adcq_word_fmt fmt_i (
        .head  (head_entry),
        .empty (empty),
        .word  (rd_data)
    );

    // pop_ok is consumed inside the controller; kept visible for the checker
    logic unused_pop;
    assign unused_pop = pop_ok;

endmodule

// File: rtl/adc_result_queue_chk.sv
module adc_result_queue_chk
    import adcq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              rd_strobe,
    input logic [WORD_W-1:0] rd_data,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [CNT_W-1:0]  count,
    input logic              full,
    input logic              empty
);

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && rd_ptr == '0 && wr_ptr == '0 && empty && !full && rd_data == '0));

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_data[WORD_W-1:16] == '0 && rd_data[5:4] == 2'b00));

    assert_pop_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !empty) |=> rd_ptr == nxt($past(rd_ptr)));

    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && empty) |-> rd_data == '0);

    assert_empty_read_still_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && empty) |=> rd_ptr == $past(rd_ptr));

    assert_full_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_strobe) |-> !in_ready);

    assert_full_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_strobe) |=> (wr_ptr == $past(wr_ptr) && count == $past(count)));

    assert_full_swap_R7: assert property (@(posedge clk) disable iff (rst)
        (full && rd_strobe && in_valid) |=> (full && count == CNT_W'(DEPTH)));

    assert_push_advance_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> wr_ptr == nxt($past(wr_ptr)));

    assert_both_steady_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && rd_strobe && !empty) |=> count == $past(count));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (count <= CNT_W'(DEPTH) && !(full && empty)));

endmodule

bind adc_result_queue adc_result_queue_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/adc_result_queue_tb.sv
module adc_result_queue_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [9:0]  in_value = '0;
    logic [3:0]  in_tag = '0;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  rd_ptr;
    logic [3:0]  wr_ptr;
    logic [4:0]  count;
    logic        full;
    logic        empty;

    always #10 clk = ~clk;  // 50 MHz

    adc_result_queue dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_value(in_value), .in_tag(in_tag), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .count(count), .full(full), .empty(empty)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of the queue contents, indexed like the storage array
    int q_val [16];
    int q_tag [16];
    int hd  = 0;
    int tl  = 0;
    int cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "rd_ptr", rd_ptr, hd);
        chk(req, "wr_ptr", wr_ptr, tl);
        chk(req, "count", count, cnt);
        chk("R10", "full", full, cnt == 16);
        chk("R10", "empty", empty, cnt == 0);
    endtask

    // One bus cycle; called and returning at a falling edge
    task automatic step(input bit v, input int val, input int tg, input bit rd);
        bit pop, push, rdy;
        longint exp_word;
        string req;
        in_valid  = v;
        in_value  = val[9:0];
        in_tag    = tg[3:0];
        rd_strobe = rd;
        #1;
        exp_word = (cnt == 0) ? 0 : ((longint'(q_val[hd]) << 6) | q_tag[hd]);
        chk((cnt == 0) ? "R5" : "R2/R3", "rd_data", rd_data, exp_word);
        pop  = rd && (cnt > 0);
        rdy  = (cnt < 16) || pop;
        chk((cnt == 16) ? (rd ? "R7" : "R6") : "R8", "in_ready", in_ready, rdy);
        push = v && rdy;
        if      (cnt == 16 && push && pop) req = "R7";
        else if (push && pop)              req = "R9";
        else if (pop)                      req = "R4";
        else if (push)                     req = "R8";
        else if (rd)                       req = "R5";
        else if (v)                        req = "R6";
        else                               req = "R4";
        if (push) begin
            q_val[tl] = val & 10'h3FF;
            q_tag[tl] = tg & 4'hF;
            tl = (tl + 1) % 16;
        end
        if (pop) hd = (hd + 1) % 16;
        cnt = cnt + int'(push) - int'(pop);
        @(posedge clk);
        @(negedge clk);
        in_valid  = 1'b0;
        rd_strobe = 1'b0;
        check_state(req);
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hd = 0; tl = 0; cnt = 0;
        #1;
        check_state("R1");
        chk("R1", "rd_data", rd_data, 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        reset_dut();

        // Fill with arithmetic values, hit every tag, then over-offer while full
        for (int i = 0; i < 16; i++) step(1, (i * 37 + 5) % 1024, 15 - i, 0);
        chk("R6", "full after 16", full, 1);
        for (int i = 0; i < 4; i++) step(1, 1023, 15, 0);
        // Drain in order; the stalled offers must not appear
        for (int i = 0; i < 16; i++) step(0, 0, 0, 1);
        chk("R5", "empty after drain", empty, 1);

        // Strobes on an empty queue
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1);

        // Field boundaries: all-ones sample and tag, then all-zero
        step(1, 1023, 15, 0);
        step(1, 0, 0, 0);
        step(1, 1023, 0, 0);
        step(1, 0, 15, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1);

        // Fill, then sustained push+retire on a full queue
        for (int i = 0; i < 16; i++) step(1, i * 61 % 1024, i, 0);
        for (int i = 0; i < 40; i++) step(1, (i * 113 + 7) % 1024, (i * 5) % 16, 1);
        for (int i = 0; i < 16; i++) step(0, 0, 0, 1);

        // Pseudo-random interleaving, fill-biased then drain-biased
        for (int ph = 0; ph < 6; ph++) begin
            for (int i = 0; i < 400; i++) begin
                bit v, rd;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (ph % 2 == 0) begin
                    v  = lfsr[0] | lfsr[1];
                    rd = lfsr[2] & lfsr[3];
                end else begin
                    v  = lfsr[0] & lfsr[1];
                    rd = lfsr[2] | lfsr[3];
                end
                step(v, int'(lfsr[15:6]), int'(lfsr[9:6]), rd);
            end
        end

        // Reset with entries stored clears everything
        for (int i = 0; i < 5; i++) step(1, 100 + i, i, 0);
        reset_dut();
        step(0, 0, 0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule